// File: doc/BRIEF.md
# I2C Acknowledge and Arbitration Monitor

This block runs beside the byte engine of a multi-master I2C controller. It watches the bus while bytes move and keeps a small set of status bits for the controller. The first is a last-bit flag. When an acknowledge clock is used, this flag holds the acknowledge result. When no acknowledge clock is used, it holds the final data bit of the byte. The block also keeps an arbitration-lost flag and the two mode bits, transmit/receive (TRX) and master/slave (MST).

Both bus lines pass through a synchronizer. SDA is compared with the locally driven value on each rising edge of the synchronized SCL. If SDA reads low while the local side is releasing it during master transmit, arbitration is lost. The block then sets the flag, switches TRX to receive in the same cycle, and stops pulling SDA low. MST stays set until the byte that lost arbitration has finished.

A byte is tracked by five named states:
- ST_IDLE: no byte in progress.
- ST_SHIFT: data bits, counted by the bit-clock strobe.
- ST_ACK: the acknowledge clock.
- ST_SHIFT_LOST: data bits after arbitration was lost.
- ST_ACK_LOST: the acknowledge clock after arbitration was lost.

The transitions are:
- A data-register write moves any state to ST_SHIFT with the bit count at zero.
- A loss detected in ST_SHIFT moves to ST_SHIFT_LOST.
- The final data strobe leaves ST_SHIFT for ST_ACK, or for ST_IDLE when the acknowledge clock is off.
- The final data strobe leaves ST_SHIFT_LOST for ST_ACK_LOST, or for ST_IDLE when the acknowledge clock is off. On that strobe MST clears if the next state is ST_IDLE.
- One strobe leaves ST_ACK or ST_ACK_LOST for ST_IDLE. Leaving ST_ACK_LOST clears MST.
- A low interface enable or a soft-reset request forces ST_IDLE.

Top module: `i2c_arb_ack_mon`

## Requirements
- R1: SDA is compared only on a rising edge of the synchronized SCL. SDA held low against a released local drive while SCL stays low never sets the arbitration-lost flag.
- R2: With the acknowledge clock enabled, the last-bit flag after the byte is 0 when SDA was low (acknowledged) during the acknowledge clock, and 1 when it was high.
- R3: With the acknowledge clock disabled, the last-bit flag after the byte equals the eighth (final, least significant) data bit sampled on SDA.
- R4: A data-register write clears the last-bit flag to 0 on the next clock.
- R5: In master transmit (MST=1, TRX=1), a data bit where SDA is sampled low while the local drive is 1 sets the arbitration-lost flag.
- R6: TRX becomes 0 (receive) on the same clock edge that sets the arbitration-lost flag.
- R7: After a loss, MST stays 1 until the last bit-clock strobe of that byte. That is the ninth strobe with the acknowledge clock enabled, or the eighth without it. MST becomes 0 on that strobe.
- R8: No arbitration loss is flagged in master receive (TRX=0) or in slave mode (MST=0), whatever SDA does.
- R9: The arbitration-lost flag is 0 one clock after a data-register write, a low interface enable, or a soft-reset request.
- R10: After a loss, sda_out is 1 for the rest of that byte whatever sda_drive is. After the byte, sda_out follows sda_drive again.
- R11: After reset, the last-bit flag, the arbitration-lost flag, TRX and MST are all 0, and sda_out follows sda_drive.
- R12: A mode write loads MST from mode_mst and TRX from mode_trx on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL level seen on the bus |
| sda_in | input | 1 | SDA level seen on the bus |
| sda_drive | input | 1 | Local SDA value from the byte engine (1 = release) |
| bit_stb | input | 1 | One-cycle strobe at the end of each bit clock |
| ack_en | input | 1 | Acknowledge clock follows the eight data bits |
| dat_wr | input | 1 | Data-register write strobe; starts a byte |
| mode_wr | input | 1 | Mode write strobe |
| mode_mst | input | 1 | MST value loaded by a mode write |
| mode_trx | input | 1 | TRX value loaded by a mode write |
| if_en | input | 1 | Interface enable |
| soft_rst | input | 1 | Soft-reset request |
| lrb_flag | output | 1 | Last received bit / acknowledge result |
| al_flag | output | 1 | Arbitration lost |
| trx_flag | output | 1 | 1 = transmit, 0 = receive |
| mst_flag | output | 1 | 1 = master, 0 = slave |
| sda_out | output | 1 | SDA value to the pad, forced to 1 after a loss |

## Verification
The bench loses arbitration in the first data bit with the acknowledge clock enabled. It checks that TRX falls at once while MST survives the eighth data strobe and falls only on the acknowledge strobe. A design that drops MST together with TRX, or counts one clock short, fails there. Bytes with and without the acknowledge clock show whether the flag takes the acknowledge or the last data bit. Receive and slave bytes with SDA pulled low catch a detector that ignores the mode bits. A low SDA with SCL held low catches a comparison made on levels rather than edges. Each of the three clear sources is applied to a set flag in turn.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_SHIFT      = 3'd1,
        ST_ACK        = 3'd2,
        ST_SHIFT_LOST = 3'd3,
        ST_ACK_LOST   = 3'd4
    } mon_state_e;

endpackage

// File: rtl/i2c_mon_sync.sv
module i2c_mon_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= RST_VAL;
                else        chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= RST_VAL;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/i2c_mon_front.sv
module i2c_mon_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise
);

    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] synced;
    logic              scl_prev;

    assign raw = {sda_in, scl_in};

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        i2c_mon_sync #(
            .STAGES (SYNC_STAGES),
            .RST_VAL(1'b1)
        ) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (raw[i]),
            .q    (synced[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) scl_prev <= 1'b1;
        else        scl_prev <= synced[0];
    end

    assign sda_s    = synced[1];
    assign scl_rise = synced[0] & ~scl_prev;

endmodule

// File: rtl/i2c_mon_seq.sv
module i2c_mon_seq
    import i2c_mon_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic if_en,
    input  logic soft_rst,
    input  logic dat_wr,
    input  logic bit_stb,
    input  logic ack_en,
    input  logic arb_hit,
    output logic data_phase,
    output logic ack_phase,
    output logic lost,
    output logic last_bit,
    output logic byte_drop
);

    localparam int             CW       = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [CW-1:0]  LAST_IDX = CW'(DATA_BITS - 1);

    mon_state_e     state, state_nx;
    logic [CW-1:0]  cnt, cnt_nx;
    logic           hold;

    assign hold = !if_en || soft_rst;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        if (hold) begin
            state_nx = ST_IDLE;
            cnt_nx   = '0;
        end else if (dat_wr) begin
            state_nx = ST_SHIFT;
            cnt_nx   = '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                end
                ST_SHIFT: begin
                    if (bit_stb && cnt == LAST_IDX) begin
                        cnt_nx   = '0;
                        state_nx = ack_en ? ST_ACK : ST_IDLE;
                    end else begin
                        if (bit_stb) cnt_nx = cnt + 1'b1;
                        if (arb_hit) state_nx = ST_SHIFT_LOST;
                    end
                end
                ST_SHIFT_LOST: begin
                    if (bit_stb) begin
                        if (cnt == LAST_IDX) begin
                            cnt_nx   = '0;
                            state_nx = ack_en ? ST_ACK_LOST : ST_IDLE;
                        end else begin
                            cnt_nx = cnt + 1'b1;
                        end
                    end
                end
                ST_ACK, ST_ACK_LOST: begin
                    if (bit_stb) state_nx = ST_IDLE;
                end
                default: begin
                    state_nx = ST_IDLE;
                    cnt_nx   = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        data_phase = (state == ST_SHIFT) || (state == ST_SHIFT_LOST);
        ack_phase  = (state == ST_ACK)   || (state == ST_ACK_LOST);
        lost       = (state == ST_SHIFT_LOST) || (state == ST_ACK_LOST);
        last_bit   = (cnt == LAST_IDX);
        byte_drop  = !hold && !dat_wr && bit_stb &&
                     (((state == ST_SHIFT_LOST) && last_bit && !ack_en) ||
                      (state == ST_ACK_LOST));
    end

endmodule

// File: rtl/i2c_mon_flags.sv
module i2c_mon_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic if_en,
    input  logic soft_rst,
    input  logic dat_wr,
    input  logic mode_wr,
    input  logic mode_mst,
    input  logic mode_trx,
    input  logic ack_en,
    input  logic scl_rise,
    input  logic sda_s,
    input  logic sda_drive,
    input  logic data_phase,
    input  logic ack_phase,
    input  logic lost,
    input  logic last_bit,
    input  logic byte_drop,
    output logic arb_hit,
    output logic lrb,
    output logic al,
    output logic trx,
    output logic mst
);

    logic al_clr;
    logic lrb_take;

    assign al_clr   = !if_en || soft_rst || dat_wr;
    assign arb_hit  = !al_clr && data_phase && !lost && mst && trx &&
                      scl_rise && sda_drive && !sda_s;
    assign lrb_take = scl_rise &&
                      ((data_phase && last_bit && !ack_en) ||
                       (ack_phase && ack_en));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        lrb <= 1'b0;
        else if (dat_wr)   lrb <= 1'b0;
        else if (lrb_take) lrb <= sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       al <= 1'b0;
        else if (al_clr)  al <= 1'b0;
        else if (arb_hit) al <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trx <= 1'b0;
            mst <= 1'b0;
        end else if (mode_wr) begin
            trx <= mode_trx;
            mst <= mode_mst;
        end else begin
            if (arb_hit)   trx <= 1'b0;
            if (byte_drop) mst <= 1'b0;
        end
    end

endmodule

// File: rtl/i2c_arb_ack_mon.sv
module i2c_arb_ack_mon #(
    parameter int SYNC_STAGES = 2,
    parameter int DATA_BITS   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic sda_drive,
    input  logic bit_stb,
    input  logic ack_en,
    input  logic dat_wr,
    input  logic mode_wr,
    input  logic mode_mst,
    input  logic mode_trx,
    input  logic if_en,
    input  logic soft_rst,
    output logic lrb_flag,
    output logic al_flag,
    output logic trx_flag,
    output logic mst_flag,
    output logic sda_out
);

    logic sda_s, scl_rise;
    logic data_phase, ack_phase, lost, last_bit, byte_drop, arb_hit;

    i2c_mon_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_in  (scl_in),
        .sda_in  (sda_in),
        .sda_s   (sda_s),
        .scl_rise(scl_rise)
    );

    i2c_mon_seq #(.DATA_BITS(DATA_BITS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .if_en     (if_en),
        .soft_rst  (soft_rst),
        .dat_wr    (dat_wr),
        .bit_stb   (bit_stb),
        .ack_en    (ack_en),
        .arb_hit   (arb_hit),
        .data_phase(data_phase),
        .ack_phase (ack_phase),
        .lost      (lost),
        .last_bit  (last_bit),
        .byte_drop (byte_drop)
    );

    i2c_mon_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .if_en     (if_en),
        .soft_rst  (soft_rst),
        .dat_wr    (dat_wr),
        .mode_wr   (mode_wr),
        .mode_mst  (mode_mst),
        .mode_trx  (mode_trx),
        .ack_en    (ack_en),
        .scl_rise  (scl_rise),
        .sda_s     (sda_s),
        .sda_drive (sda_drive),
        .data_phase(data_phase),
        .ack_phase (ack_phase),
        .lost      (lost),
        .last_bit  (last_bit),
        .byte_drop (byte_drop),
        .arb_hit   (arb_hit),
        .lrb       (lrb_flag),
        .al        (al_flag),
        .trx       (trx_flag),
        .mst       (mst_flag)
    );

    // R10: stop pulling SDA low once arbitration is lost
    assign sda_out = sda_drive | lost;

endmodule

// File: rtl/i2c_arb_ack_mon_chk.sv
module i2c_arb_ack_mon_chk (
    input logic clk,
    input logic rst_n,
    input logic if_en,
    input logic soft_rst,
    input logic dat_wr,
    input logic mode_wr,
    input logic bit_stb,
    input logic lrb_flag,
    input logic al_flag,
    input logic trx_flag,
    input logic mst_flag,
    input logic sda_out
);

    // R4
    lrb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dat_wr |=> !lrb_flag);

    // R6
    al_trx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(al_flag) && !$past(mode_wr)) |-> !trx_flag);

    // R8
    al_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(al_flag) |-> $past(mst_flag && trx_flag));

    // R7
    mst_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mst_flag) && !$past(mode_wr)) |-> $past(bit_stb && al_flag));

    // R9
    al_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr || !if_en || soft_rst) |=> !al_flag);

    // R10
    sda_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(al_flag) |-> sda_out);

endmodule

bind i2c_arb_ack_mon i2c_arb_ack_mon_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .if_en   (if_en),
    .soft_rst(soft_rst),
    .dat_wr  (dat_wr),
    .mode_wr (mode_wr),
    .bit_stb (bit_stb),
    .lrb_flag(lrb_flag),
    .al_flag (al_flag),
    .trx_flag(trx_flag),
    .mst_flag(mst_flag),
    .sda_out (sda_out)
);

// File: tb/sim_i2c_arb_ack_mon.sv
`timescale 1ns/1ps
module sim_i2c_arb_ack_mon;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_in = 1'b1, sda_in = 1'b1, sda_drive = 1'b1;
    logic bit_stb = 1'b0, ack_en = 1'b0, dat_wr = 1'b0;
    logic mode_wr = 1'b0, mode_mst = 1'b0, mode_trx = 1'b0;
    logic if_en = 1'b0, soft_rst = 1'b0;
    logic lrb_flag, al_flag, trx_flag, mst_flag, sda_out;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    i2c_arb_ack_mon u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_drive(sda_drive), .bit_stb(bit_stb), .ack_en(ack_en),
        .dat_wr(dat_wr), .mode_wr(mode_wr), .mode_mst(mode_mst),
        .mode_trx(mode_trx), .if_en(if_en), .soft_rst(soft_rst),
        .lrb_flag(lrb_flag), .al_flag(al_flag), .trx_flag(trx_flag),
        .mst_flag(mst_flag), .sda_out(sda_out)
    );

    typedef struct packed {
        logic       mst;
        logic       trx;
        logic       ack;
        logic [7:0] drv;
        logic [7:0] oth;
        logic       ackb;
        logic       e_lrb;
        logic       e_al;
        logic       e_trx;
        logic       e_mst;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b1, 1'b1, 8'hA5, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
        '{1'b1, 1'b1, 1'b1, 8'hA5, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
        '{1'b1, 1'b1, 1'b0, 8'h3C, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
        '{1'b1, 1'b1, 1'b0, 8'h3D, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
        '{1'b1, 1'b1, 1'b1, 8'hFF, 8'hF7, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{1'b1, 1'b0, 1'b1, 8'hFF, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
        '{1'b0, 1'b1, 1'b1, 8'hFF, 8'h0F, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        '{1'b1, 1'b1, 1'b0, 8'h7F, 8'hBF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_dat_wr();
        dat_wr = 1'b1; cyc(1); dat_wr = 1'b0; cyc(1);
    endtask

    task automatic set_mode(input logic m, input logic t);
        mode_mst = m; mode_trx = t; mode_wr = 1'b1; cyc(1);
        mode_wr = 1'b0; cyc(1);
    endtask

    task automatic do_bit(input logic drv, input logic bus);
        sda_drive = drv; sda_in = bus; cyc(4);
        scl_in = 1'b1; cyc(4);
        scl_in = 1'b0; cyc(3);
        bit_stb = 1'b1; cyc(1); bit_stb = 1'b0; cyc(2);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        // R11 reset state
        chk("R11 lrb", lrb_flag, 1'b0);
        chk("R11 al", al_flag, 1'b0);
        chk("R11 trx", trx_flag, 1'b0);
        chk("R11 mst", mst_flag, 1'b0);
        chk("R11 sda_out", sda_out, 1'b1);
        if_en = 1'b1;
        cyc(2);

        // table walk: R2 R3 R5 R6 R7 R8
        for (int v = 0; v < NVEC; v++) begin
            set_mode(VECS[v].mst, VECS[v].trx);
            chk("R12 mst", mst_flag, VECS[v].mst);
            ack_en = VECS[v].ack;
            pulse_dat_wr();
            for (int b = 7; b >= 0; b--)
                do_bit(VECS[v].drv[b], VECS[v].drv[b] & VECS[v].oth[b]);
            if (VECS[v].ack) do_bit(1'b1, VECS[v].ackb);
            chk(VECS[v].ack ? "R2 lrb" : "R3 lrb", lrb_flag, VECS[v].e_lrb);
            chk("R5/R8 al", al_flag, VECS[v].e_al);
            chk("R6 trx", trx_flag, VECS[v].e_trx);
            chk("R7 mst", mst_flag, VECS[v].e_mst);
        end

        // R4: data write clears lrb (last vector left it at 1)
        chk("R4 lrb before", lrb_flag, 1'b1);
        pulse_dat_wr();
        chk("R4 lrb", lrb_flag, 1'b0);

        // R1: low SDA with SCL held low never flags
        set_mode(1'b1, 1'b1);
        pulse_dat_wr();
        sda_drive = 1'b1; sda_in = 1'b0; cyc(12);
        chk("R1 al", al_flag, 1'b0);
        chk("R1 trx", trx_flag, 1'b1);
        sda_in = 1'b1; cyc(2);

        // R7/R10: loss in first bit with acknowledge clock
        ack_en = 1'b1;
        set_mode(1'b1, 1'b1);
        pulse_dat_wr();
        do_bit(1'b1, 1'b0);
        chk("R5 al", al_flag, 1'b1);
        chk("R6 trx", trx_flag, 1'b0);
        chk("R7 mst held", mst_flag, 1'b1);
        sda_drive = 1'b0; cyc(1);
        chk("R10 sda_out", sda_out, 1'b1);
        for (int b = 0; b < 7; b++) do_bit(1'b0, 1'b1);
        chk("R7 mst after 8 data", mst_flag, 1'b1);
        chk("R10 sda_out in ack", sda_out, 1'b1);
        do_bit(1'b0, 1'b0);
        chk("R7 mst after ack", mst_flag, 1'b0);
        sda_drive = 1'b0; cyc(1);
        chk("R10 sda_out follows", sda_out, 1'b0);
        sda_drive = 1'b1; cyc(1);

        // R9: soft reset clears al
        set_mode(1'b1, 1'b1);
        pulse_dat_wr();
        do_bit(1'b1, 1'b0);
        chk("R9 al set", al_flag, 1'b1);
        soft_rst = 1'b1; cyc(1); soft_rst = 1'b0; cyc(1);
        chk("R9 al soft", al_flag, 1'b0);

        // R9: disable clears al
        set_mode(1'b1, 1'b1);
        pulse_dat_wr();
        do_bit(1'b1, 1'b0);
        chk("R9 al set", al_flag, 1'b1);
        if_en = 1'b0; cyc(1); if_en = 1'b1; cyc(1);
        chk("R9 al disable", al_flag, 1'b0);

        // R9: data write clears al
        set_mode(1'b1, 1'b1);
        pulse_dat_wr();
        do_bit(1'b1, 1'b0);
        chk("R9 al set", al_flag, 1'b1);
        pulse_dat_wr();
        chk("R9 al write", al_flag, 1'b0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule